// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs the byte-level part of single-bit instructions. It takes an 8-bit destination byte, a bit index and the current carry and zero flags. It returns the byte to write back, a write enable, and the new carry and zero flags. Memory access and operand fetch stay with the surrounding datapath: the block only works out what the selected bit does to the byte and to the flags.

There are fourteen operations. Set, clear, flip, store and inverted store rewrite the selected bit and ask for write-back. Test changes only the zero flag. Load, AND, OR and XOR, each with a form that complements the selected bit first, change only the carry flag. All results are registered, so they appear one clock after the operands are presented. A new operation can be accepted on every cycle.

Top module: `bitop_unit`

## Requirements
- R1: The selected bit position is the bit index modulo 8. Index values 8 to 15 therefore act exactly like 0 to 7.
- R2: Opcode 0 (set), 1 (clear) and 2 (flip) force the selected bit to 1, to 0, or to its complement. They leave every other bit unchanged, assert the write enable, and pass C and Z through.
- R3: Opcode 3 (test) deasserts the write enable and sets Z to the complement of the selected bit. C passes through unchanged.
- R4: Opcode 4 (load) copies the selected bit into C. Opcode 5 (inverted load) copies its complement into C. Both deassert the write enable and leave Z unchanged.
- R5: Opcode 6 (store) writes C into the selected bit. Opcode 7 (inverted store) writes the complement of C. Both assert the write enable, leave the other bits unchanged, and pass C and Z through.
- R6: Opcodes 8/10/12 set C to C AND, C OR or C XOR the selected bit. Opcodes 9/11/13 do the same with the complement of the selected bit. All of them deassert the write enable and leave Z unchanged.
- R7: Opcodes 14 and 15 are undefined. They deassert the write enable and pass the byte, C and Z through unchanged.
- R8: When the write enable is deasserted, the output byte equals the input byte.
- R9: While reset is asserted, the byte, the write enable, C and Z outputs are all 0.
- R10: The results for the operands presented before a rising clock edge appear on the outputs after that edge. Back-to-back operations are accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (see R2 to R7) |
| byte_i | input | 8 | Destination byte |
| idx_i | input | 4 | Bit index (taken modulo 8) |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| byte_o | output | 8 | Byte to write back |
| we_o | output | 1 | Write-back enable |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |

## Verification
The assertions check on every cycle that a result byte differs from its operand in at most the selected bit. They also check that Z moves only on test, that C stays put on the writing operations and on test, that a non-writing result returns the operand byte, and that undefined codes have no effect. What a value should be cannot be seen structurally: the exact value of each rewritten bit, the carry produced by each logic combination and its inverted twin, and the aliasing of indices 8 to 15. Those come from the bench, which compares random and directed operations against an independent model of each opcode.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    BOP_SET    = 4'd0,
    BOP_CLR    = 4'd1,
    BOP_FLIP   = 4'd2,
    BOP_TEST   = 4'd3,
    BOP_LOAD   = 4'd4,
    BOP_LOADN  = 4'd5,
    BOP_STORE  = 4'd6,
    BOP_STOREN = 4'd7,
    BOP_AND    = 4'd8,
    BOP_ANDN   = 4'd9,
    BOP_OR     = 4'd10,
    BOP_ORN    = 4'd11,
    BOP_XOR    = 4'd12,
    BOP_XORN   = 4'd13
  } bop_e;

  typedef enum logic [2:0] {
    WK_NONE, WK_SET, WK_CLR, WK_FLIP, WK_STORE
  } wr_kind_e;

  typedef enum logic [2:0] {
    CK_KEEP, CK_LOAD, CK_AND, CK_OR, CK_XOR
  } cf_kind_e;

  typedef struct packed {
    wr_kind_e wk;
    cf_kind_e ck;
    logic     inv;   // complement bit (or C for store) before use
    logic     tst;
  } bop_ctrl_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [3:0] op_i,
  output bop_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{wk: WK_NONE, ck: CK_KEEP, inv: 1'b0, tst: 1'b0};
    case (op_i)
      BOP_SET:    ctrl_o.wk = WK_SET;
      BOP_CLR:    ctrl_o.wk = WK_CLR;
      BOP_FLIP:   ctrl_o.wk = WK_FLIP;
      BOP_TEST:   ctrl_o.tst = 1'b1;
      BOP_LOAD:   ctrl_o.ck = CK_LOAD;
      BOP_LOADN:  begin ctrl_o.ck = CK_LOAD; ctrl_o.inv = 1'b1; end
      BOP_STORE:  ctrl_o.wk = WK_STORE;
      BOP_STOREN: begin ctrl_o.wk = WK_STORE; ctrl_o.inv = 1'b1; end
      BOP_AND:    ctrl_o.ck = CK_AND;
      BOP_ANDN:   begin ctrl_o.ck = CK_AND; ctrl_o.inv = 1'b1; end
      BOP_OR:     ctrl_o.ck = CK_OR;
      BOP_ORN:    begin ctrl_o.ck = CK_OR; ctrl_o.inv = 1'b1; end
      BOP_XOR:    ctrl_o.ck = CK_XOR;
      BOP_XORN:   begin ctrl_o.ck = CK_XOR; ctrl_o.inv = 1'b1; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/bitop_select.sv
module bitop_select #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              bit_o
);
  // DATA_W is a power of two: modulo keeps the low index bits
  logic [IDX_W-1:0] pos;
  assign pos = idx_i % IDX_W'(DATA_W);

  for (genvar k = 0; k < DATA_W; k++) begin : g_mask
    assign mask_o[k] = (pos == IDX_W'(k));
  end

  assign bit_o = |(byte_i & mask_o);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              we_o,
  output logic              c_o,
  output logic              z_o
);
  bop_ctrl_t         ctrl;
  logic [DATA_W-1:0] mask;
  logic              sel_bit;
  logic              eff_bit;
  logic              lane_val;
  logic [DATA_W-1:0] nxt_byte;
  logic              nxt_we;
  logic              nxt_c;
  logic              nxt_z;

  bitop_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  bitop_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .byte_i (byte_i),
    .idx_i  (idx_i),
    .mask_o (mask),
    .bit_o  (sel_bit)
  );

  assign eff_bit = sel_bit ^ ctrl.inv;

  always_comb begin
    case (ctrl.wk)
      WK_SET:   lane_val = 1'b1;
      WK_CLR:   lane_val = 1'b0;
      WK_FLIP:  lane_val = ~sel_bit;
      WK_STORE: lane_val = c_i ^ ctrl.inv;
      default:  lane_val = sel_bit;
    endcase
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_lane
    assign nxt_byte[k] = mask[k] ? lane_val : byte_i[k];
  end

  assign nxt_we = (ctrl.wk != WK_NONE);

  always_comb begin
    case (ctrl.ck)
      CK_LOAD: nxt_c = eff_bit;
      CK_AND:  nxt_c = eff_bit & c_i;
      CK_OR:   nxt_c = eff_bit | c_i;
      CK_XOR:  nxt_c = eff_bit ^ c_i;
      default: nxt_c = c_i;
    endcase
  end

  assign nxt_z = ctrl.tst ? ~sel_bit : z_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      we_o   <= 1'b0;
      c_o    <= 1'b0;
      z_o    <= 1'b0;
    end else begin
      byte_o <= nxt_byte;
      we_o   <= nxt_we;
      c_o    <= nxt_c;
      z_o    <= nxt_z;
    end
  end

  // one cycle of history exists once this is set
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  // R2
  one_bit_touched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> $countones(byte_o ^ $past(byte_i)) <= 1);

  // R3
  z_only_on_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(op_i) != 4'd3) |-> z_o == $past(z_i));

  // R5
  c_kept_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(op_i) <= 4'd7 && $past(op_i) != 4'd4
            && $past(op_i) != 4'd5) |-> c_o == $past(c_i));

  // R8
  passthru_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !we_o) |-> byte_o == $past(byte_i));

  // R7
  undef_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(op_i) >= 4'd14) |->
      (!we_o && c_o == $past(c_i) && z_o == $past(z_i)));

  // R6
  logic_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(op_i) >= 4'd8 && $past(op_i) <= 4'd13) |-> !we_o);
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] byt = '0;
  logic [3:0] idx = '0;
  logic       cin = 1'b0;
  logic       zin = 1'b0;
  logic [7:0] byte_out;
  logic       we_out, c_out, z_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .op_i   (op),
    .byte_i (byt),
    .idx_i  (idx),
    .c_i    (cin),
    .z_i    (zin),
    .byte_o (byte_out),
    .we_o   (we_out),
    .c_o    (c_out),
    .z_o    (z_out)
  );

  // expected {byte, we, c, z}
  function automatic logic [10:0] model(input logic [3:0] o, input logic [7:0] b,
                                        input logic [3:0] ix, input logic c, input logic z);
    int p;
    logic bt;
    logic [7:0] rb;
    logic rw, rc, rz;
    p  = int'(ix) & 7;
    bt = b[p];
    rb = b; rw = 1'b0; rc = c; rz = z;
    case (o)
      4'd0:  begin rb[p] = 1'b1; rw = 1'b1; end
      4'd1:  begin rb[p] = 1'b0; rw = 1'b1; end
      4'd2:  begin rb[p] = ~bt;  rw = 1'b1; end
      4'd3:  rz = (bt == 1'b0);
      4'd4:  rc = bt;
      4'd5:  rc = ~bt;
      4'd6:  begin rb[p] = c;  rw = 1'b1; end
      4'd7:  begin rb[p] = ~c; rw = 1'b1; end
      4'd8:  rc = c & bt;
      4'd9:  rc = c & ~bt;
      4'd10: rc = c | bt;
      4'd11: rc = c | ~bt;
      4'd12: rc = c ^ bt;
      4'd13: rc = c ^ ~bt;
      default: ;
    endcase
    return {rb, rw, rc, rz};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    if (o <= 4'd2) return "R2";
    if (o == 4'd3) return "R3";
    if (o <= 4'd5) return "R4";
    if (o <= 4'd7) return "R5";
    if (o <= 4'd13) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // present one operation, sample after the registering edge (R10)
  task automatic run_op(input logic [3:0] o, input logic [7:0] b, input logic [3:0] ix,
                        input logic c, input logic z, input string tag);
    logic [10:0] e;
    @(negedge clk);
    op = o; byt = b; idx = ix; cin = c; zin = z;
    e = model(o, b, ix, c, z);
    @(negedge clk);
    check(tag, "byte", int'(byte_out), int'(e[10:3]));
    check(tag, "we",   int'(we_out),   int'(e[2]));
    check(tag, "c",    int'(c_out),    int'(e[1]));
    check(tag, "z",    int'(z_out),    int'(e[0]));
    if (!e[2]) check("R8", "passthru", int'(byte_out), int'(b));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op = 4'd0; byt = 8'hA5; idx = 4'd3; cin = 1'b1; zin = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "byte", int'(byte_out), 0);
    check("R9", "we",   int'(we_out),   0);
    check("R9", "c",    int'(c_out),    0);
    check("R9", "z",    int'(z_out),    0);
    rst_n = 1'b1;

    // directed: R2 corner positions
    run_op(4'd0, 8'h00, 4'd7, 1'b0, 1'b0, "R2");
    run_op(4'd1, 8'hFF, 4'd0, 1'b1, 1'b1, "R2");
    run_op(4'd2, 8'h5A, 4'd4, 1'b0, 1'b1, "R2");
    // R1 aliasing: index 9 acts as 1, index 15 as 7
    run_op(4'd0, 8'h00, 4'd9, 1'b0, 1'b0, "R1");
    check("R1", "alias9", int'(byte_out), 8'h02);
    run_op(4'd1, 8'hFF, 4'd15, 1'b0, 1'b0, "R1");
    check("R1", "alias15", int'(byte_out), 8'h7F);
    // R3 test both polarities
    run_op(4'd3, 8'h10, 4'd4, 1'b1, 1'b1, "R3");
    run_op(4'd3, 8'hEF, 4'd4, 1'b0, 1'b0, "R3");
    // R4 load / inverted load
    run_op(4'd4, 8'h80, 4'd7, 1'b0, 1'b1, "R4");
    run_op(4'd5, 8'h80, 4'd7, 1'b1, 1'b0, "R4");
    // R5 store / inverted store
    run_op(4'd6, 8'h00, 4'd2, 1'b1, 1'b0, "R5");
    run_op(4'd7, 8'h00, 4'd2, 1'b1, 1'b0, "R5");
    // R6 all logic ops on each bit/carry pair
    for (int o = 8; o <= 13; o++)
      for (int v = 0; v < 4; v++)
        run_op(4'(o), v[0] ? 8'h08 : 8'h00, 4'd3, v[1], 1'b0, "R6");
    // R7 undefined codes
    run_op(4'd14, 8'h3C, 4'd2, 1'b1, 1'b0, "R7");
    run_op(4'd15, 8'hC3, 4'd6, 1'b0, 1'b1, "R7");

    // R10 back-to-back: two ops on consecutive cycles
    @(negedge clk);
    op = 4'd0; byt = 8'h00; idx = 4'd5; cin = 1'b0; zin = 1'b0;
    @(negedge clk);
    check("R10", "first", int'(byte_out), 8'h20);
    op = 4'd4; byt = 8'h01; idx = 4'd0; cin = 1'b0; zin = 1'b1;
    @(negedge clk);
    check("R10", "second_c", int'(c_out), 1);
    check("R10", "second_we", int'(we_out), 0);

    // random
    for (int n = 0; n < 600; n++) begin
      logic [3:0] ro;
      ro = 4'($urandom_range(0, 15));
      run_op(ro, 8'($urandom), 4'($urandom_range(0, 15)),
             1'($urandom), 1'($urandom), tag_of(ro));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule